// File: doc/BRIEF.md
# Regulator Fault and Power-Good Supervisor

This block sits between the analog comparators of a single-phase buck regulator and its gate-drive and status logic. It takes already-digitized comparator flags (overvoltage against two possible thresholds, undervoltage against the DAC target, overcurrent, the two controller-supply crossings and thermal) together with the enable input, a soft-start-active flag and an offset-mode select. From them it produces the power-good output, a gate-disable command, a force-low-side-on command, a compensation clamp command and a latched shutdown flag.

Overvoltage is handled in two stages. Each excursion clamps the output by forcing the low-side switch on, and the clamp releases when the excursion ends. The events are counted, and the eighth counted event latches a shutdown. Events that occur while soft-start is active are not counted. This lets the regulator pull a pre-charged output down to the target without tripping. An overcurrent trip latches the gates off until enable is dropped or the supply falls below its stop threshold. Power-good drops on the edge after a bad condition appears and rises only after a programmable run of good cycles.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is asserted, pgood=0, gateOff=1, forceLowOn=0, compPull=1 and shutdown=0.
- R2: Supply state: supBelowStop=1 clears it, supAboveStart=1 (without supBelowStop) sets it, and with neither flag set it holds. While it is clear, gateOff=1 and forceLowOn=0.
- R3: offsetMode=0 selects ovNarrow as the overvoltage flag and offsetMode=1 selects ovWide. The unselected flag has no effect on forceLowOn.
- R4: While the selected overvoltage flag is high and the gates are not otherwise disabled, forceLowOn=1 and pgood=0. forceLowOn falls on the first edge after the flag drops.
- R5: A counted overvoltage event is a 0-to-1 change of the selected flag. On the OV_LIMIT-th counted event (default 8), shutdown latches to 1, gateOff=1 and forceLowOn=0.
- R6: Overvoltage rises seen while softStartActive=1 are not counted and never cause shutdown. The clamp of R4 still applies during soft-start.
- R7: uvFlag=1 drives pgood to 0 on the next clock edge.
- R8: pgood rises only on the PG_RISE-th consecutive edge (default 12, about 240 ns at 50 MHz) at which enable, supply, no thermal, no overvoltage, no undervoltage, no soft-start and no latched fault all hold.
- R9: ocFlag=1 while enabled and supplied latches gateOff=1. The latch holds after ocFlag drops and clears only through enable=0 or a supply drop.
- R10: enable=0 or a supply drop clears the overvoltage event count and the shutdown latch.
- R11: thermFlag=1 forces gateOff=1 on the next edge. The effect is not latched and releases on the edge after thermFlag drops.
- R12: compPull=1 exactly when gateOff=1 or forceLowOn=1. All outputs are registered and respond on the first clock edge that samples the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enable; low clears all latched faults |
| ovNarrow | input | 1 | Overvoltage flag, normal-margin comparator |
| ovWide | input | 1 | Overvoltage flag, wide-margin comparator used in offset mode |
| offsetMode | input | 1 | Selects the wide overvoltage comparator |
| uvFlag | input | 1 | Output is more than the undervoltage margin below the DAC |
| ocFlag | input | 1 | Overcurrent comparator flag |
| supAboveStart | input | 1 | Controller supply above its start threshold |
| supBelowStop | input | 1 | Controller supply below its stop threshold |
| thermFlag | input | 1 | Over-temperature flag |
| softStartActive | input | 1 | Soft-start ramp in progress |
| pgood | output | 1 | Power-good status |
| gateOff | output | 1 | Both gates held off |
| forceLowOn | output | 1 | Low-side switch forced on, high side off |
| compPull | output | 1 | Compensation node clamp |
| shutdown | output | 1 | Latched overvoltage shutdown |

## Verification
Every result except the power-good rise appears on the first rising edge after the input changes. The bench therefore drives inputs just after a falling edge and samples one falling edge later, when exactly one rising edge has passed. The power-good rise is due PG_RISE edges after the last bad condition clears. It is checked low at PG_RISE-1 edges and high at PG_RISE edges. Overvoltage pulses are one cycle high and one cycle low, so each pulse gives exactly one counted rise. Sticky behaviour is confirmed by sampling several cycles after the trigger is removed.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  // Strobes handed from the control stage to the datapath each cycle.
  typedef struct packed {
    logic clrLatch;   // enable low or supply not valid: wipe count and latches
    logic ovCount;    // counted overvoltage rise (outside soft-start)
    logic ocTrip;     // overcurrent seen while live
    logic ovPresent;  // selected overvoltage flag level
    logic baseOff;    // gates off for non-latched reasons
    logic pgCond;     // raw good condition before latched faults
  } fsupStrobe_t;
endpackage

// File: rtl/fsup_sticky.sv
module fsup_sticky (
  input  logic clk,
  input  logic rstN,
  input  logic setIn,
  input  logic clrIn,
  output logic qNext,
  output logic q
);
  // clear takes priority over set
  always_comb qNext = clrIn ? 1'b0 : (q | setIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= 1'b0;
    else       q <= qNext;
  end
endmodule

// File: rtl/fsup_ctrl.sv
module fsup_ctrl
  import fsup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        ovNarrow,
  input  logic        ovWide,
  input  logic        offsetMode,
  input  logic        uvFlag,
  input  logic        ocFlag,
  input  logic        supAboveStart,
  input  logic        supBelowStop,
  input  logic        thermFlag,
  input  logic        softStartActive,
  output fsupStrobe_t strb
);
  logic supplyOkQ, supplyOkN;
  logic ovSel, ovSelQ;
  logic live;

  // Supply hysteresis: stop crossing wins, start crossing sets, else hold.
  always_comb begin
    if (supBelowStop)       supplyOkN = 1'b0;
    else if (supAboveStart) supplyOkN = 1'b1;
    else                    supplyOkN = supplyOkQ;
  end

  always_comb ovSel = offsetMode ? ovWide : ovNarrow;
  always_comb live  = enable & supplyOkN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supplyOkQ <= 1'b0;
      ovSelQ    <= 1'b0;
    end else begin
      supplyOkQ <= supplyOkN;
      ovSelQ    <= ovSel;
    end
  end

  always_comb begin
    strb.clrLatch  = ~live;
    strb.ovCount   = live & ovSel & ~ovSelQ & ~softStartActive;
    strb.ocTrip    = live & ocFlag;
    strb.ovPresent = ovSel;
    strb.baseOff   = ~live | thermFlag;
    strb.pgCond    = live & ~thermFlag & ~ovSel & ~uvFlag & ~softStartActive;
  end

  AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!supBelowStop && !supAboveStart) |=> $stable(supplyOkQ)); // R2
  AST_SOFTSTART_NOCOUNT: assert property (@(posedge clk) disable iff (!rstN)
    softStartActive |-> !strb.ovCount); // R6
endmodule

// File: rtl/fsup_dp.sv
module fsup_dp
  import fsup_pkg::*;
#(
  parameter int OV_LIMIT = 8,
  parameter int PG_RISE  = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  fsupStrobe_t strb,
  output logic        pgood,
  output logic        gateOff,
  output logic        forceLowOn,
  output logic        compPull,
  output logic        shutdown
);
  localparam int OVW = $clog2(OV_LIMIT + 1);
  localparam int PGW = $clog2(PG_RISE + 1);
  localparam logic [OVW-1:0] OV_MAX  = OVW'(OV_LIMIT);
  localparam logic [OVW-1:0] OV_LAST = OVW'(OV_LIMIT - 1);
  localparam logic [PGW-1:0] PG_MAX  = PGW'(PG_RISE);

  logic [OVW-1:0] ovCnt, ovCntN;
  logic [PGW-1:0] pgCnt, pgCntN;
  logic ocNext, ocQ, shutNext, shutQ, shutSet;
  logic gateOffN, forceN, pgAll, pgoodN;

  // Overvoltage event counter, saturating at the limit.
  always_comb begin
    if (strb.clrLatch)                     ovCntN = '0;
    else if (strb.ovCount && ovCnt != OV_MAX) ovCntN = ovCnt + 1'b1;
    else                                   ovCntN = ovCnt;
  end
  always_comb shutSet = strb.ovCount && (ovCnt == OV_LAST);

  fsup_sticky u_ocLatch (
    .clk(clk), .rstN(rstN), .setIn(strb.ocTrip), .clrIn(strb.clrLatch),
    .qNext(ocNext), .q(ocQ)
  );
  fsup_sticky u_shutLatch (
    .clk(clk), .rstN(rstN), .setIn(shutSet), .clrIn(strb.clrLatch),
    .qNext(shutNext), .q(shutQ)
  );

  always_comb begin
    gateOffN = strb.baseOff | ocNext | shutNext;
    forceN   = strb.ovPresent & ~gateOffN;
    pgAll    = strb.pgCond & ~ocNext & ~shutNext;
    if (!pgAll)               pgCntN = '0;
    else if (pgCnt == PG_MAX) pgCntN = pgCnt;
    else                      pgCntN = pgCnt + 1'b1;
    pgoodN   = pgAll && (pgCntN == PG_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovCnt      <= '0;
      pgCnt      <= '0;
      pgood      <= 1'b0;
      gateOff    <= 1'b1;
      forceLowOn <= 1'b0;
      compPull   <= 1'b1;
    end else begin
      ovCnt      <= ovCntN;
      pgCnt      <= pgCntN;
      pgood      <= pgoodN;
      gateOff    <= gateOffN;
      forceLowOn <= forceN;
      compPull   <= gateOffN | forceN;
    end
  end

  always_comb shutdown = shutQ;

  AST_OVCNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ovCnt <= OV_MAX); // R5
  AST_SHUT_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutQ) |-> $past(ovCnt) == OV_LAST); // R5
  AST_PG_RISE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgood) |-> $past(pgCnt) == PGW'(PG_RISE - 1)); // R8
  AST_OC_NO_PGOOD: assert property (@(posedge clk) disable iff (!rstN)
    ocQ |-> !pgood); // R9
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int OV_LIMIT = 8,
  parameter int PG_RISE  = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic ovNarrow,
  input  logic ovWide,
  input  logic offsetMode,
  input  logic uvFlag,
  input  logic ocFlag,
  input  logic supAboveStart,
  input  logic supBelowStop,
  input  logic thermFlag,
  input  logic softStartActive,
  output logic pgood,
  output logic gateOff,
  output logic forceLowOn,
  output logic compPull,
  output logic shutdown
);
  fsupStrobe_t strb;

  fsup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .ovNarrow(ovNarrow), .ovWide(ovWide), .offsetMode(offsetMode),
    .uvFlag(uvFlag), .ocFlag(ocFlag),
    .supAboveStart(supAboveStart), .supBelowStop(supBelowStop),
    .thermFlag(thermFlag), .softStartActive(softStartActive),
    .strb(strb)
  );

  fsup_dp #(.OV_LIMIT(OV_LIMIT), .PG_RISE(PG_RISE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pgood(pgood), .gateOff(gateOff), .forceLowOn(forceLowOn),
    .compPull(compPull), .shutdown(shutdown)
  );

  AST_UVLO_GATES: assert property (@(posedge clk) disable iff (!rstN)
    supBelowStop |=> (gateOff && !forceLowOn)); // R2
  AST_PG_FALL: assert property (@(posedge clk) disable iff (!rstN)
    uvFlag |=> !pgood); // R7
  AST_SOFTSTART_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (softStartActive && !shutdown) |=> !shutdown); // R6
  AST_THERM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    thermFlag |=> gateOff); // R11
endmodule

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;
  localparam int PG  = 12;
  localparam int OVL = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, enable = 1'b0, ovNarrow = 1'b0, ovWide = 1'b0;
  logic offsetMode = 1'b0, uvFlag = 1'b0, ocFlag = 1'b0;
  logic supAboveStart = 1'b0, supBelowStop = 1'b0, thermFlag = 1'b0;
  logic softStartActive = 1'b0;
  logic pgood, gateOff, forceLowOn, compPull, shutdown;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  fault_supervisor #(.OV_LIMIT(OVL), .PG_RISE(PG)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .ovNarrow(ovNarrow),
    .ovWide(ovWide), .offsetMode(offsetMode), .uvFlag(uvFlag),
    .ocFlag(ocFlag), .supAboveStart(supAboveStart),
    .supBelowStop(supBelowStop), .thermFlag(thermFlag),
    .softStartActive(softStartActive), .pgood(pgood), .gateOff(gateOff),
    .forceLowOn(forceLowOn), .compPull(compPull), .shutdown(shutdown)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic ovPulse();
    ovNarrow = 1'b1; step(1);
    ovNarrow = 1'b0; step(1);
  endtask

  task automatic tReset();
    step(2);
    chk(pgood, 1'b0, "R1", "pgood in reset");
    chk(gateOff, 1'b1, "R1", "gateOff in reset");
    chk(forceLowOn, 1'b0, "R1", "forceLowOn in reset");
    chk(compPull, 1'b1, "R1", "compPull in reset");
    chk(shutdown, 1'b0, "R1", "shutdown in reset");
    rstN = 1'b1;
    step(1);
  endtask

  task automatic tPowerUp();
    enable = 1'b1; supAboveStart = 1'b1; step(1);
    supAboveStart = 1'b0;
    chk(gateOff, 1'b0, "R2", "gates on after start crossing");
    chk(compPull, 1'b0, "R12", "clamp released");
    step(PG - 2);
    chk(pgood, 1'b0, "R8", "pgood one edge early");
    step(1);
    chk(pgood, 1'b1, "R8", "pgood after rise run");
  endtask

  task automatic tUnder();
    uvFlag = 1'b1; step(1);
    chk(pgood, 1'b0, "R7", "pgood drops on undervoltage");
    chk(gateOff, 1'b0, "R7", "undervoltage leaves gates on");
    uvFlag = 1'b0; step(PG - 1);
    chk(pgood, 1'b0, "R8", "pgood early after uv");
    step(1);
    chk(pgood, 1'b1, "R8", "pgood back after uv");
  endtask

  task automatic tOvClamp();
    ovNarrow = 1'b1; step(1);
    chk(forceLowOn, 1'b1, "R4", "clamp on overvoltage");
    chk(pgood, 1'b0, "R4", "pgood low on overvoltage");
    chk(compPull, 1'b1, "R12", "comp clamp during ov");
    chk(gateOff, 1'b0, "R4", "gateOff stays low during clamp");
    step(3);
    chk(forceLowOn, 1'b1, "R4", "clamp held");
    ovNarrow = 1'b0; step(1);
    chk(forceLowOn, 1'b0, "R4", "clamp released");
    chk(compPull, 1'b0, "R12", "comp clamp released");
  endtask

  task automatic tOffsetSel();
    ovWide = 1'b1; step(1);
    chk(forceLowOn, 1'b0, "R3", "wide flag ignored in normal mode");
    ovWide = 1'b0;
    offsetMode = 1'b1; ovNarrow = 1'b1; step(1);
    chk(forceLowOn, 1'b0, "R3", "narrow flag ignored in offset mode");
    ovNarrow = 1'b0; ovWide = 1'b1; step(1);
    chk(forceLowOn, 1'b1, "R3", "wide flag clamps in offset mode");
    ovWide = 1'b0; step(1);
    offsetMode = 1'b0; step(1);
    chk(forceLowOn, 1'b0, "R3", "clamp off after wide clears");
  endtask

  task automatic tSoftStart();
    softStartActive = 1'b1;
    for (int i = 0; i < 10; i++) begin
      ovNarrow = 1'b1; step(1);
      if (i == 0) chk(forceLowOn, 1'b1, "R6", "clamp active in soft-start");
      ovNarrow = 1'b0; step(1);
    end
    chk(shutdown, 1'b0, "R6", "no shutdown from soft-start events");
    chk(gateOff, 1'b0, "R6", "gates still on after soft-start events");
    softStartActive = 1'b0; step(1);
  endtask

  task automatic tOvShutdown();
    enable = 1'b0; step(1);
    enable = 1'b1; step(1);
    for (int i = 0; i < OVL - 1; i++) ovPulse();
    chk(shutdown, 1'b0, "R5", "no shutdown before last event");
    ovNarrow = 1'b1; step(1);
    chk(shutdown, 1'b1, "R5", "shutdown on last event");
    chk(gateOff, 1'b1, "R5", "gates off at shutdown");
    chk(forceLowOn, 1'b0, "R5", "low side released at shutdown");
    ovNarrow = 1'b0; step(4);
    chk(shutdown, 1'b1, "R5", "shutdown latched");
    enable = 1'b0; step(1);
    chk(shutdown, 1'b0, "R10", "enable low clears shutdown");
    enable = 1'b1; step(1);
    chk(gateOff, 1'b0, "R10", "gates back after enable cycle");
  endtask

  task automatic tSupplyClears();
    for (int i = 0; i < OVL - 1; i++) ovPulse();
    supBelowStop = 1'b1; step(1);
    chk(gateOff, 1'b1, "R2", "gates off below stop");
    chk(forceLowOn, 1'b0, "R2", "no low side below stop");
    supBelowStop = 1'b0; step(2);
    chk(gateOff, 1'b1, "R2", "hysteresis holds off");
    supAboveStart = 1'b1; step(1);
    supAboveStart = 1'b0;
    chk(gateOff, 1'b0, "R2", "gates on after restart");
    ovPulse();
    chk(shutdown, 1'b0, "R10", "supply drop cleared event count");
  endtask

  task automatic tOverCurrent();
    ocFlag = 1'b1; step(1);
    ocFlag = 1'b0;
    chk(gateOff, 1'b1, "R9", "overcurrent disables gates");
    chk(pgood, 1'b0, "R9", "pgood low on overcurrent");
    step(5);
    chk(gateOff, 1'b1, "R9", "overcurrent latched");
    enable = 1'b0; step(1);
    enable = 1'b1; step(1);
    chk(gateOff, 1'b0, "R9", "enable cycle clears overcurrent");
    ocFlag = 1'b1; step(1);
    ocFlag = 1'b0; step(2);
    chk(gateOff, 1'b1, "R9", "second overcurrent latched");
    supBelowStop = 1'b1; step(1);
    supBelowStop = 1'b0; supAboveStart = 1'b1; step(1);
    supAboveStart = 1'b0;
    chk(gateOff, 1'b0, "R9", "supply cycle clears overcurrent");
  endtask

  task automatic tThermal();
    thermFlag = 1'b1; step(1);
    chk(gateOff, 1'b1, "R11", "thermal disables gates");
    chk(compPull, 1'b1, "R12", "comp clamp on thermal");
    thermFlag = 1'b0; step(1);
    chk(gateOff, 1'b0, "R11", "thermal not latched");
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    tReset();
    tPowerUp();
    tUnder();
    tOvClamp();
    tOffsetSel();
    tSoftStart();
    tOvShutdown();
    tSupplyClears();
    tOverCurrent();
    tThermal();
    finishRun();
  end
endmodule